// File: doc/BRIEF.md
# System Reset Control Register

This block is a one-byte I/O-mapped control register through which software asks the platform to reset itself. It watches an I/O address bus with separate read and write strobes. When a write to its port carries the trigger bit, it raises a one-cycle reset-request pulse for an external reset sequencer. That write leaves the register contents alone. Any other write to the port keeps only the reset-type bit and drops every other bit.

Reads of the port return the stored byte on the low lane of a wider, little-endian data bus. Accesses to any other address do nothing, and while no read of the port is under way the read data stays at zero. The block does not decide what a hard or a soft reset means. It only holds the type bit for the sequencer, which acts on the request.

Top module: `sys_rst_ctl`

## Requirements
- R1: After rst_ni is released, the stored byte reads as 0x00 and rst_req_o is low.
- R2: Only I/O address 0x0CF9 selects the register; a write to any other address changes neither the stored byte nor rst_req_o, and a read of any other address returns zero.
- R3: A write to 0x0CF9 whose data bit 2 is 1 drives rst_req_o high in the cycle after the write strobe, for exactly one cycle per strobed cycle.
- R4: A write to 0x0CF9 whose data bit 2 is 1 leaves the stored byte unchanged.
- R5: A write to 0x0CF9 whose data bit 2 is 0 sets the stored byte to the write data ANDed with 0x02, so only bit 1 (reset type) is kept.
- R6: A read strobe at 0x0CF9 returns the stored byte on rd_data_o bits 7:0 in the same cycle, with all higher bits zero; write data bits above 7 never reach the register.
- R7: When rd_en_i is low, rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | I/O address |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | 32 | Write data; byte lane 0 carries the register |
| rd_data_o | output | 32 | Read data; register in lane 0, zero elsewhere |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions check on every cycle that the register never holds a bit other than the type bit, that a trigger write is followed by the pulse while the contents stay frozen, that a missed write causes no change and no pulse, and that an idle read bus is zero. Only the bench scenarios can show the value that reads back after each of the 256 byte patterns, with noise in the upper lanes. The same goes for the effect of single-bit address errors around the port and for the reset state.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int unsigned TRIG_BIT     = 2;
  localparam int unsigned TYPE_BIT     = 1;
  localparam logic [15:0] PORT_DEFAULT = 16'h0CF9;
endpackage

// File: rtl/srst_decode.sv
module srst_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic match;
  assign match    = (io_addr_i == PORT_ADDR);
  assign wr_hit_o = wr_en_i & match;
  assign rd_hit_o = rd_en_i & match;
endmodule

// File: rtl/srst_store.sv
module srst_store #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned TRIG_BIT = 2,
  parameter int unsigned TYPE_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [REG_W-1:0]  q_o,
  output logic              fire_o
);
  localparam logic [REG_W-1:0] KEEP = REG_W'(1) << TYPE_BIT;

  logic [REG_W-1:0] lane0;
  assign lane0  = wr_data_i[REG_W-1:0];
  assign fire_o = wr_hit_i & lane0[TRIG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          q_o <= '0;
    else if (wr_hit_i && !lane0[TRIG_BIT]) q_o <= lane0 & KEEP;
  end

  assert_only_type_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~KEEP) == '0);
endmodule

// File: rtl/srst_pulse.sv
module srst_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= fire_i;
  end
endmodule

// File: rtl/sys_rst_ctl.sv
module sys_rst_ctl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(srst_pkg::PORT_DEFAULT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rst_req_o
);
  logic             wr_hit, rd_hit, fire;
  logic [REG_W-1:0] q;

  srst_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .io_addr_i(io_addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wr_hit_o(wr_hit), .rd_hit_o(rd_hit)
  );

  srst_store #(.DATA_W(DATA_W), .REG_W(REG_W),
               .TRIG_BIT(srst_pkg::TRIG_BIT), .TYPE_BIT(srst_pkg::TYPE_BIT)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_hit_i(wr_hit), .wr_data_i(wr_data_i),
    .q_o(q), .fire_o(fire)
  );

  srst_pulse u_pulse (.clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .req_o(rst_req_o));

  // register sits in little-endian lane 0
  generate
    if (DATA_W > REG_W) begin : g_pad
      assign rd_data_o = rd_hit ? {{(DATA_W-REG_W){1'b0}}, q} : '0;
    end else begin : g_flat
      assign rd_data_o = rd_hit ? q : '0;
    end
  endgenerate

  assert_trig_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && io_addr_i == PORT_ADDR && wr_data_i[srst_pkg::TRIG_BIT]) |=> rst_req_o);

  assert_pulse_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wr_en_i && io_addr_i == PORT_ADDR && wr_data_i[srst_pkg::TRIG_BIT]));

  assert_trig_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && io_addr_i == PORT_ADDR && wr_data_i[srst_pkg::TRIG_BIT]) |=> $stable(q));

  assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i != PORT_ADDR) |=> ($stable(q) && !rst_req_o));

  assert_idle_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == '0);
endmodule

// File: tb/sys_rst_ctl_tb_top.sv
module sys_rst_ctl_tb_top;
  localparam logic [15:0] PORT = 16'h0CF9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q = 8'h00;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sys_rst_ctl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write cycle, then check the pulse cycle and the cycle after
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string req);
    logic exp_p;
    exp_p = (a == PORT) && d[2];
    @(negedge clk_i);
    io_addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; io_addr_i = '0; wr_data_i = '0;
    chk(req, {31'b0, rst_req_o}, {31'b0, exp_p});
    @(negedge clk_i);
    chk({req, " pulse width"}, {31'b0, rst_req_o}, 32'h0);
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    io_addr_i = a; rd_en_i = 1'b1;
    #1 chk(req, rd_data_o, exp);
    @(negedge clk_i);
    rd_en_i = 1'b0; io_addr_i = '0;
    #1 chk("R7", rd_data_o, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 req", {31'b0, rst_req_o}, 32'h0);
    rd(PORT, 32'h0, "R1 value");

    // R5/R6: every lane-0 pattern with upper-lane noise
    for (int b = 0; b < 256; b++) begin
      logic [31:0] d;
      d = {b[7:0], b[7:0] ^ 8'hA5, ~b[7:0], b[7:0]};
      if (b[2]) begin
        wr(PORT, d, "R3");
        rd(PORT, {24'h0, exp_q}, "R4");
      end else begin
        exp_q = b[7:0] & 8'h02;
        wr(PORT, d, "R3 no pulse");
        rd(PORT, {24'h0, exp_q}, "R5/R6");
      end
    end

    // R4 trigger with type bit clear must not wipe a stored 0x02
    wr(PORT, 32'h0000_0002, "R5 set");
    exp_q = 8'h02;
    wr(PORT, 32'h0000_0004, "R3 trigger");
    rd(PORT, 32'h0000_0002, "R4 keep");

    // R3 back-to-back triggers: one pulse cycle each
    @(negedge clk_i);
    io_addr_i = PORT; wr_data_i = 32'h6; wr_en_i = 1'b1;
    @(negedge clk_i);
    chk("R3 first", {31'b0, rst_req_o}, 32'h1);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R3 second", {31'b0, rst_req_o}, 32'h1);
    @(negedge clk_i);
    chk("R3 end", {31'b0, rst_req_o}, 32'h0);

    // R2 single-bit address errors around the port
    wr(PORT, 32'h0, "R5 clear");
    exp_q = 8'h00;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = PORT ^ (16'h1 << i);
      wr(a, 32'h0000_0002, "R2 store miss");
      wr(a, 32'h0000_0006, "R2 trigger miss");
      rd(a, 32'h0, "R2 read miss");
      rd(PORT, {24'h0, exp_q}, "R2 unchanged");
    end
    wr(16'h0CF8, 32'h0000_0202, "R2 neighbour");
    rd(PORT, 32'h0, "R2 neighbour unchanged");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule